// File: doc/BRIEF.md
# Main Clock Loss Supervisor

This block watches a main clock from a free-running reference clock domain and keeps the system clocked when the main clock dies. Each main-clock rising edge flips a toggle bit. A two-flop synchronizer carries that bit into the reference domain, where a counter measures the gap between edges. If the gap reaches a parameterised number of reference cycles, the block declares the main clock lost. It then moves the system clock to a slower backup source through a glitch-free switch and sets a sticky detection flag. When software has enabled it and the global mask is open, it also raises an interrupt.

After every reset the block holds the system in reset until the first main-clock edge is seen. A device that has no main clock therefore never starts. In halt mode the supervisor is fully off: its configuration reads as disabled, the backup oscillator enable drops and no detection or interrupt occurs. The block saves the configuration on halt entry. When halt is left by an interrupt, that saved configuration comes back. When the device wakes through reset, the reset values apply instead.

Top module: `mclk_sentinel`

## Requirements
- R1: After reset is released, `sys_rst` stays 1 for as long as no main-clock edge has been seen. It falls within a few reference cycles after the main clock starts toggling.
- R2: Reset sets `stat_enable` to the value of `cfg_on` and clears `stat_ie`. It also clears `loss_flag`, `on_backup` and `irq`.
- R3: While the supervisor is enabled and not halted, a gap of `TIMEOUT` reference cycles with no main-clock edge sets `loss_flag` and `on_backup` together. From then on, `sys_clk` is driven by `backup_clk`.
- R4: With `stat_enable` at 0, a stopped main clock neither sets `loss_flag` nor changes `on_backup`.
- R5: `loss_flag` stays set until a write with `wr_data` bit 2 at 1 clears it, or until reset.
- R6: `on_backup` stays 1 until reset, even when the main clock returns.
- R7: `irq` is 1 one cycle after `loss_flag`, `stat_ie` and a low `gmask` hold together, and 0 otherwise.
- R8: `sys_clk` carries no pulse shorter than the shorter half period of the two sources. The main and backup clock gates are never open at the same time.
- R9: While `halt` is 1, `stat_enable`, `stat_ie`, `bk_osc_on` and `irq` are 0, and a stopped main clock is not detected.
- R10: When `halt` falls without a reset, the enable and interrupt-enable values from before halt return. If reset occurs during halt, the R2 values apply.
- R11: A pulse on `wr_stb` loads `wr_data` bit 0 into the enable bit and bit 1 into the interrupt-enable bit. Writes made while `halt` is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock, also clocks the control logic |
| rst | input | 1 | Synchronous active-high reset |
| main_clk | input | 1 | Supervised main clock |
| backup_clk | input | 1 | Slower backup clock |
| cfg_on | input | 1 | Enable value loaded at reset |
| wr_stb | input | 1 | Control write strobe |
| wr_data | input | 3 | Bit 0 enable, bit 1 interrupt enable, bit 2 clear flag |
| gmask | input | 1 | Global interrupt mask, 1 blocks the interrupt |
| halt | input | 1 | Halt mode request |
| sys_clk | output | 1 | Selected system clock |
| sys_rst | output | 1 | System reset hold |
| on_backup | output | 1 | System clock taken from backup |
| loss_flag | output | 1 | Sticky clock-loss flag |
| irq | output | 1 | Interrupt request |
| stat_enable | output | 1 | Current enable bit |
| stat_ie | output | 1 | Current interrupt-enable bit |
| bk_osc_on | output | 1 | Backup oscillator enable |

## Verification
The main clock is started late, to show the reset hold. It is then stopped with the supervisor enabled, with it disabled and during halt. The three stops separate real detection from the gating by enable and by halt. After failover, the interrupt is swept through mask and interrupt-enable settings, and the flag is cleared while the main clock returns. This separates flag stickiness from selection stickiness. Every edge of `sys_clk` is timed throughout, so a runt pulse at a switch shows up as a short width. Halt is left once by its falling edge and once through reset, and a write is made during halt, to tell the restore, default and ignored-write paths apart.

// File: rtl/sentinel_pkg.sv
package sentinel_pkg;
  localparam int WB_EN  = 0;
  localparam int WB_IE  = 1;
  localparam int WB_CLR = 2;
  localparam int WR_W   = 3;

  typedef struct packed {
    logic ie;
    logic en;
  } sup_cfg_t;
endpackage

// File: rtl/sentinel_edge_watch.sv
module sentinel_edge_watch #(
  parameter int TIMEOUT = 8
) (
  input  logic ref_clk,
  input  logic rst,
  input  logic main_clk,
  input  logic active,
  output logic edge_o,
  output logic lost_o
);
  localparam int CW = $clog2(TIMEOUT + 1);

  logic tog = 1'b0;
  logic s1 = 1'b0, s2 = 1'b0, s3 = 1'b0;
  logic [CW-1:0] cnt;
  logic seen_edge;

  always_ff @(posedge main_clk) tog <= ~tog;

  // no reset on the synchronizer: a reset must not fake an edge
  always_ff @(posedge ref_clk) begin
    s1 <= tog;
    s2 <= s1;
    s3 <= s2;
  end

  assign seen_edge = s2 ^ s3;

  always_ff @(posedge ref_clk) begin
    if (rst) begin
      cnt    <= '0;
      edge_o <= 1'b0;
      lost_o <= 1'b0;
    end else begin
      edge_o <= seen_edge;
      lost_o <= 1'b0;
      if (!active || seen_edge) begin
        cnt <= '0;
      end else if (cnt == CW'(TIMEOUT - 1)) begin
        cnt    <= '0;
        lost_o <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sentinel_clk_switch.sv
module sentinel_clk_switch (
  input  logic main_clk,
  input  logic backup_clk,
  input  logic sel_backup,
  output logic clk_out,
  output logic en_main,
  output logic en_backup
);
  logic mb1 = 1'b0, mb2 = 1'b0;
  logic em = 1'b0;
  logic bb1 = 1'b0, eb = 1'b0;

  always_ff @(negedge main_clk) begin
    mb1 <= eb;
    mb2 <= mb1;
  end

  // asynchronous clear: a dead main clock cannot close its own gate
  always_ff @(negedge main_clk or posedge sel_backup) begin
    if (sel_backup) em <= 1'b0;
    else            em <= ~mb2;
  end

  always_ff @(negedge backup_clk) begin
    bb1 <= sel_backup & ~em;
    eb  <= bb1;
  end

  assign en_main   = em;
  assign en_backup = eb;
  assign clk_out   = (main_clk & em) | (backup_clk & eb);
endmodule

// File: rtl/mclk_sentinel.sv
module mclk_sentinel
  import sentinel_pkg::*;
#(
  parameter int TIMEOUT = 8
) (
  input  logic            ref_clk,
  input  logic            rst,
  input  logic            main_clk,
  input  logic            backup_clk,
  input  logic            cfg_on,
  input  logic            wr_stb,
  input  logic [WR_W-1:0] wr_data,
  input  logic            gmask,
  input  logic            halt,
  output logic            sys_clk,
  output logic            sys_rst,
  output logic            on_backup,
  output logic            loss_flag,
  output logic            irq,
  output logic            stat_enable,
  output logic            stat_ie,
  output logic            bk_osc_on
);
  sup_cfg_t live, saved;
  logic halt_q, seen, edge_p, lost_p, watch_on;
  logic en_main, en_backup;

  assign watch_on = live.en & ~halt & seen & ~on_backup;

  sentinel_edge_watch #(.TIMEOUT(TIMEOUT)) u_watch (
    .ref_clk (ref_clk),
    .rst     (rst),
    .main_clk(main_clk),
    .active  (watch_on),
    .edge_o  (edge_p),
    .lost_o  (lost_p)
  );

  sentinel_clk_switch u_switch (
    .main_clk  (main_clk),
    .backup_clk(backup_clk),
    .sel_backup(on_backup),
    .clk_out   (sys_clk),
    .en_main   (en_main),
    .en_backup (en_backup)
  );

  always_ff @(posedge ref_clk) begin
    if (rst) begin
      live      <= '{ie: 1'b0, en: cfg_on};
      saved     <= '{ie: 1'b0, en: cfg_on};
      halt_q    <= 1'b0;
      seen      <= 1'b0;
      sys_rst   <= 1'b1;
      on_backup <= 1'b0;
      loss_flag <= 1'b0;
      irq       <= 1'b0;
      bk_osc_on <= 1'b0;
    end else begin
      halt_q <= halt;
      if (halt && !halt_q) begin
        saved <= live;
        live  <= '0;
      end else if (!halt && halt_q) begin
        live <= saved;
      end else if (wr_stb && !halt) begin
        live.en <= wr_data[WB_EN];
        live.ie <= wr_data[WB_IE];
      end

      if (lost_p)
        loss_flag <= 1'b1;
      else if (wr_stb && !halt && wr_data[WB_CLR])
        loss_flag <= 1'b0;

      on_backup <= on_backup | lost_p;
      seen      <= seen | edge_p;
      sys_rst   <= ~seen;
      irq       <= loss_flag & live.ie & ~gmask & ~halt;
      bk_osc_on <= live.en & ~halt;
    end
  end

  assign stat_enable = live.en;
  assign stat_ie     = live.ie;
endmodule

// File: rtl/sentinel_chk.sv
module sentinel_chk (
  input logic       ref_clk,
  input logic       rst,
  input logic       wr_stb,
  input logic [2:0] wr_data,
  input logic       gmask,
  input logic       halt,
  input logic       on_backup,
  input logic       loss_flag,
  input logic       irq,
  input logic       stat_enable,
  input logic       en_main,
  input logic       en_backup
);
  p_flag_sticky_r5: assert property (@(posedge ref_clk) disable iff (rst)
    loss_flag && !(wr_stb && wr_data[2]) |=> loss_flag);

  p_backup_sticky_r6: assert property (@(posedge ref_clk) disable iff (rst)
    on_backup |=> on_backup);

  p_flag_needs_backup_r3: assert property (@(posedge ref_clk) disable iff (rst)
    loss_flag |-> on_backup);

  p_halt_quiet_r9: assert property (@(posedge ref_clk) disable iff (rst)
    halt && $past(halt) |-> !irq && !stat_enable);

  p_gates_exclusive_r8: assert property (@(posedge ref_clk) disable iff (rst)
    !(en_main && en_backup));

  p_irq_mask_r7: assert property (@(posedge ref_clk) disable iff (rst)
    irq |-> !$past(gmask));
endmodule

bind mclk_sentinel sentinel_chk u_chk (
  .ref_clk    (ref_clk),
  .rst        (rst),
  .wr_stb     (wr_stb),
  .wr_data    (wr_data),
  .gmask      (gmask),
  .halt       (halt),
  .on_backup  (on_backup),
  .loss_flag  (loss_flag),
  .irq        (irq),
  .stat_enable(stat_enable),
  .en_main    (en_main),
  .en_backup  (en_backup)
);

// File: tb/test_mclk_sentinel.sv
module test_mclk_sentinel;
  logic ref_clk = 1'b0, mclk = 1'b0, bclk = 1'b0;
  logic rst = 1'b1, cfg_on = 1'b1, wr_stb = 1'b0, gmask = 1'b1, halt = 1'b0;
  logic [2:0] wr_data = '0;
  logic main_run = 1'b0;
  logic sys_clk, sys_rst, on_backup, loss_flag, irq, stat_enable, stat_ie, bk_osc_on;

  int vectors = 0, errors = 0, glitches = 0, sys_edges = 0;
  bit done = 0;
  realtime last_edge = 0;

  typedef struct {int id; logic exp; string req;} item_t;
  item_t q[$];

  always #5 ref_clk = ~ref_clk;
  always begin #20; if (main_run) mclk = ~mclk; end
  always #30 bclk = ~bclk;

  mclk_sentinel #(.TIMEOUT(8)) i_mclk_sentinel (
    .ref_clk(ref_clk), .rst(rst), .main_clk(mclk), .backup_clk(bclk),
    .cfg_on(cfg_on), .wr_stb(wr_stb), .wr_data(wr_data), .gmask(gmask),
    .halt(halt), .sys_clk(sys_clk), .sys_rst(sys_rst), .on_backup(on_backup),
    .loss_flag(loss_flag), .irq(irq), .stat_enable(stat_enable),
    .stat_ie(stat_ie), .bk_osc_on(bk_osc_on)
  );

  // R8: time every sys_clk level; shortest legal half period is 20 ns
  always @(sys_clk) begin
    if (last_edge > 0 && ($realtime - last_edge) < 19.0) glitches++;
    last_edge = $realtime;
    sys_edges++;
  end

  function automatic logic pick(int id);
    case (id)
      0: return sys_rst;
      1: return loss_flag;
      2: return irq;
      3: return stat_enable;
      4: return stat_ie;
      5: return on_backup;
      6: return bk_osc_on;
      7: return glitches == 0;
      default: return sys_edges > 0;
    endcase
  endfunction

  // monitor: compares queued expectations away from the active edge
  always @(negedge ref_clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic act;
      it = q.pop_front();
      act = pick(it.id);
      vectors++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s signal %0d: got %b expected %b", it.req, it.id, act, it.exp);
      end
    end
  end

  task automatic expect_v(int id, logic exp, string req);
    item_t it;
    it.id = id; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge ref_clk);
    #1;
  endtask

  task automatic wr(logic [2:0] d);
    @(posedge ref_clk); #1;
    wr_stb = 1'b1; wr_data = d;
    @(posedge ref_clk); #1;
    wr_stb = 1'b0;
  endtask

  task automatic stop_main();
    @(negedge mclk);
    main_run = 1'b0;
  endtask

  task automatic pulse_rst();
    cyc(1); rst = 1'b1; cyc(3); rst = 1'b0;
  endtask

  initial begin
    cyc(4); rst = 1'b0;
    cyc(40);
    expect_v(0, 1'b1, "R1 hold without main clock");
    expect_v(1, 1'b0, "R2 flag after reset");
    expect_v(5, 1'b0, "R2 backup after reset");
    expect_v(3, 1'b1, "R2 enable from cfg_on");
    expect_v(4, 1'b0, "R2 ie after reset");
    expect_v(2, 1'b0, "R2 irq after reset");
    expect_v(6, 1'b1, "R2 osc on");

    main_run = 1'b1;
    cyc(20);
    expect_v(0, 1'b0, "R1 release on main clock");
    expect_v(5, 1'b0, "R1 main selected");

    cfg_on = 1'b0; pulse_rst(); cyc(20);
    expect_v(3, 1'b0, "R2 enable follows cfg_on=0");
    cfg_on = 1'b1; pulse_rst(); cyc(20);

    wr(3'b011); cyc(2);
    expect_v(4, 1'b1, "R11 ie written");
    expect_v(3, 1'b1, "R11 enable written");

    halt = 1'b1; cyc(4);
    expect_v(3, 1'b0, "R9 enable off in halt");
    expect_v(4, 1'b0, "R9 ie off in halt");
    expect_v(6, 1'b0, "R9 osc off in halt");
    wr(3'b000);
    stop_main(); cyc(30);
    expect_v(1, 1'b0, "R9 no detect in halt");
    expect_v(5, 1'b0, "R9 no switch in halt");
    main_run = 1'b1; cyc(10);
    halt = 1'b0; cyc(4);
    expect_v(3, 1'b1, "R10 enable restored (R11 halt write ignored)");
    expect_v(4, 1'b1, "R10 ie restored");

    halt = 1'b1; cyc(3);
    rst = 1'b1; cyc(2); halt = 1'b0; rst = 1'b0; cyc(20);
    expect_v(3, 1'b1, "R10 reset wake enable default");
    expect_v(4, 1'b0, "R10 reset wake ie default");
    expect_v(0, 1'b0, "R1 released after reset wake");

    wr(3'b000);
    stop_main(); cyc(30);
    expect_v(1, 1'b0, "R4 disabled no flag");
    expect_v(5, 1'b0, "R4 disabled no switch");
    main_run = 1'b1; cyc(10);
    wr(3'b011); cyc(4);

    stop_main(); cyc(30);
    expect_v(1, 1'b1, "R3 flag on loss");
    expect_v(5, 1'b1, "R3 backup selected");
    expect_v(2, 1'b0, "R7 masked irq");
    gmask = 1'b0; cyc(3);
    expect_v(2, 1'b1, "R7 irq raised");
    wr(3'b001); cyc(3);
    expect_v(2, 1'b0, "R7 ie cleared");
    wr(3'b011); cyc(3);
    expect_v(2, 1'b1, "R7 ie set again");
    cyc(1); sys_edges = 0; cyc(40);
    expect_v(8, 1'b1, "R3 backup drives sys_clk");
    expect_v(1, 1'b1, "R5 flag still set");

    wr(3'b111); cyc(3);
    expect_v(1, 1'b0, "R5 flag cleared by write");
    expect_v(2, 1'b0, "R7 irq drops with flag");
    expect_v(5, 1'b1, "R6 backup after clear");
    main_run = 1'b1; cyc(30);
    expect_v(5, 1'b1, "R6 backup kept with main back");
    expect_v(1, 1'b0, "R5 no new flag");

    pulse_rst(); cyc(20);
    expect_v(5, 1'b0, "R6 reset returns to main");
    expect_v(1, 1'b0, "R2 flag after final reset");
    expect_v(0, 1'b0, "R1 released with main running");
    cyc(20);
    expect_v(7, 1'b1, "R8 no short pulse on sys_clk");
    cyc(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule